// File: doc/BRIEF.md
# Two-Level Mapped Event Interrupt Controller

This block collects 64 system event inputs and presents them to software and to 10 host interrupt lines. Each event is first conditioned by its own polarity and detection type (pulse or level) and latched into a pending bit. A pending event whose enable is set is routed through a programmable event-to-channel map into one of 10 channels, and each channel is routed through a programmable channel-to-host map onto one of 10 host lines. Many events can share a channel and many channels can share a host.

Software reaches the block through a simple 32-bit register bus with a single-cycle write strobe and a combinational read. Single events are retriggered, acknowledged, unmasked and masked by writing the event number to a dedicated indexed port, so no read-modify-write of a bitmask is needed. For each host, a prioritized-index register reports the winning pending event, or flags in its top bit that nothing is pending. A handler loops on that register and acknowledges events one at a time.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the pending and enable vectors, the global enable (CTRL 0x000 bit 0), the host enables, the type registers and all map registers are 0, the polarity registers are all ones, every prioritized-index register reads 0x8000_0000, and host_irq_o is 0.
- R2: A write of event number n (0..63) to the status-set port 0x004 sets pending bit n at the next clock edge. This is the software retrigger.
- R3: A write of n to the status-clear port 0x008 clears pending bit n at the next edge, unless a new detection of event n arrives in that same cycle, in which case the bit stays set.
- R4: A write of n to 0x00C sets enable bit n, and a write of n to 0x010 clears it. A pending event whose enable bit is clear is never reported or routed.
- R5: A write to any of the four indexed ports with write data of 64 or above changes no pending and no enable bit.
- R6: Polarity words at 0x030 (events 0..31) and 0x034 (events 32..63) hold one bit per event. A 1 means the input is active high and a 0 means it is active low.
- R7: Type words at 0x038 and 0x03C hold one bit per event. A 0 selects pulse: the pending bit is set on the inactive-to-active transition, and a clear while the input stays active is kept. A 1 selects level: the pending bit is set in every cycle the input is active.
- R8: The channel map is 16 words at 0x100+4k. Event e is placed in byte e%4 of word e/4, and the low 4 bits of that byte are its channel. The host map is 3 words at 0x180+4k. Channel c is placed in byte c%4 of word c/4, and the low 4 bits of that byte are its host. A channel value of 10 or more, or a host value of 10 or more, leaves the source unrouted.
- R9: The prioritized-index register for host h at 0x200+4h reads 0x8000_0000 when no pending, enabled event is routed to h. Otherwise bit 31 is 0 and bits 9:0 hold the winning event number: the lowest channel wins, and within a channel the lowest event number wins.
- R10: host_irq_o[h] is 1 exactly when host h has a pending routed event, the global enable is 1 and host enable bit h (0x014 bits 9:0) is 1.
- R11: The pending vector reads back at 0x020/0x024 and the enable vector at 0x028/0x02C, low events in the first word. Polarity, type, map and control words read back as written, with map bytes keeping only their low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 64 | System event inputs |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| host_irq_o | output | 10 | Host interrupt lines |

## Verification
An acknowledge write on the status-clear port and a fresh active edge of the same pulse-type event can land in the same clock. The bench raises the input at the same time as it drives the clear write for that event number, then reads the pending word. The event must still be pending, because losing the new edge would drop an interrupt. A second clear with no new edge must then empty the bit, which shows the clear path itself works.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned NUM_EVT  = 64;
  localparam int unsigned NUM_CH   = 10;
  localparam int unsigned NUM_HOST = 10;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned FPR      = 4;   // map fields per word
  localparam int unsigned FLD_W    = 8;
  localparam int unsigned CH_W     = 4;
  localparam logic [31:0] FLD_MASK  = 32'h0F0F_0F0F;
  localparam logic [31:0] NONE_FLAG = 32'h8000_0000;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] ADR_SET   = 12'h004;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 12'h008;
  localparam logic [ADDR_W-1:0] ADR_ENSET = 12'h00C;
  localparam logic [ADDR_W-1:0] ADR_ENCLR = 12'h010;
  localparam logic [ADDR_W-1:0] ADR_HEN   = 12'h014;
  localparam logic [ADDR_W-1:0] ADR_PEND  = 12'h020;
  localparam logic [ADDR_W-1:0] ADR_EN    = 12'h028;
  localparam logic [ADDR_W-1:0] ADR_POL   = 12'h030;
  localparam logic [ADDR_W-1:0] ADR_TYPE  = 12'h038;
  localparam logic [ADDR_W-1:0] ADR_CMAP  = 12'h100;
  localparam logic [ADDR_W-1:0] ADR_HMAP  = 12'h180;
  localparam logic [ADDR_W-1:0] ADR_PRIDX = 12'h200;
endpackage

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned NE = NUM_EVT,
  parameter int unsigned NC = NUM_CH,
  parameter int unsigned NH = NUM_HOST,
  localparam int unsigned NW  = NE / 32,
  localparam int unsigned CMR = NE / FPR,
  localparam int unsigned HMR = (NC + FPR - 1) / FPR,
  localparam int unsigned EW  = $clog2(NE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              gen_en_o,
  output logic [NH-1:0]     host_en_o,
  output logic [NE-1:0]     pol_o,
  output logic [NE-1:0]     typ_o,
  output logic [NE-1:0]     en_o,
  output logic [31:0]       cmap_o [CMR],
  output logic [31:0]       hmap_o [HMR],
  output logic              set_o,
  output logic              clr_o,
  output logic [EW-1:0]     idx_o
);
  logic idx_ok;
  assign idx_ok = wdata_i < 32'(NE);
  assign idx_o  = wdata_i[EW-1:0];
  assign set_o  = wr_i && addr_i == ADR_SET && idx_ok;
  assign clr_o  = wr_i && addr_i == ADR_CLR && idx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_en_o  <= 1'b0;
      host_en_o <= '0;
      pol_o     <= '1;
      typ_o     <= '0;
      en_o      <= '0;
      for (int k = 0; k < CMR; k++) cmap_o[k] <= '0;
      for (int k = 0; k < HMR; k++) hmap_o[k] <= '0;
    end else if (wr_i) begin
      if (addr_i == ADR_CTRL) gen_en_o <= wdata_i[0];
      if (addr_i == ADR_HEN) host_en_o <= wdata_i[NH-1:0];
      if (addr_i == ADR_ENSET && idx_ok) en_o[idx_o] <= 1'b1;
      if (addr_i == ADR_ENCLR && idx_ok) en_o[idx_o] <= 1'b0;
      for (int k = 0; k < NW; k++) begin
        if (addr_i == ADDR_W'(ADR_POL + 4 * k))  pol_o[32*k +: 32] <= wdata_i;
        if (addr_i == ADDR_W'(ADR_TYPE + 4 * k)) typ_o[32*k +: 32] <= wdata_i;
      end
      for (int k = 0; k < CMR; k++)
        if (addr_i == ADDR_W'(ADR_CMAP + 4 * k)) cmap_o[k] <= wdata_i & FLD_MASK;
      for (int k = 0; k < HMR; k++)
        if (addr_i == ADDR_W'(ADR_HMAP + 4 * k)) hmap_o[k] <= wdata_i & FLD_MASK;
    end
  end
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
  parameter int unsigned NE = 64,
  localparam int unsigned EW = $clog2(NE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NE-1:0] evt_i,
  input  logic [NE-1:0] pol_i,
  input  logic [NE-1:0] typ_i,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [EW-1:0] idx_i,
  output logic [NE-1:0] pend_o
);
  logic [NE-1:0] act, act_q, hit, set_v, clr_v;

  assign act   = evt_i ^ ~pol_i;
  assign hit   = act & (typ_i | ~act_q);   // level: every active cycle; pulse: new edge
  assign set_v = set_i ? (NE'(1) << idx_i) : '0;
  assign clr_v = clr_i ? (NE'(1) << idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_o <= '0;
    end else begin
      act_q  <= act;
      pend_o <= (pend_o & ~clr_v) | set_v | hit;
    end
  end
endmodule

// File: rtl/evt_irq_chsel.sv
module evt_irq_chsel
  import evt_irq_pkg::*;
#(
  parameter int unsigned NE = NUM_EVT,
  parameter int unsigned NC = NUM_CH,
  localparam int unsigned CMR = NE / FPR,
  localparam int unsigned EW  = $clog2(NE)
) (
  input  logic [NE-1:0] req_i,
  input  logic [31:0]   cmap_i [CMR],
  output logic [NC-1:0] any_o,
  output logic [EW-1:0] evt_o [NC]
);
  // Scan from the top down so the lowest event number is the last to win.
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      any_o[c] = 1'b0;
      evt_o[c] = '0;
      for (int e = NE - 1; e >= 0; e--) begin
        if (req_i[e] && cmap_i[e/FPR][(e%FPR)*FLD_W +: CH_W] == CH_W'(c)) begin
          any_o[c] = 1'b1;
          evt_o[c] = EW'(e);
        end
      end
    end
  end
endmodule

// File: rtl/evt_irq_hostsel.sv
module evt_irq_hostsel
  import evt_irq_pkg::*;
#(
  parameter int unsigned NC  = NUM_CH,
  parameter int unsigned EW  = 6,
  parameter int unsigned HID = 0,
  localparam int unsigned HMR = (NC + FPR - 1) / FPR
) (
  input  logic [NC-1:0] any_i,
  input  logic [EW-1:0] evt_i [NC],
  input  logic [31:0]   hmap_i [HMR],
  input  logic          gen_en_i,
  input  logic          host_en_i,
  output logic [31:0]   pridx_o,
  output logic          irq_o
);
  logic          hit;
  logic [EW-1:0] sel;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int c = NC - 1; c >= 0; c--) begin
      if (any_i[c] && hmap_i[c/FPR][(c%FPR)*FLD_W +: CH_W] == CH_W'(HID)) begin
        hit = 1'b1;
        sel = evt_i[c];
      end
    end
  end

  assign pridx_o = hit ? 32'(sel) : NONE_FLAG;
  assign irq_o   = hit & gen_en_i & host_en_i;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned NE = NUM_EVT,
  parameter int unsigned NC = NUM_CH,
  parameter int unsigned NH = NUM_HOST,
  localparam int unsigned NW  = NE / 32,
  localparam int unsigned CMR = NE / FPR,
  localparam int unsigned HMR = (NC + FPR - 1) / FPR,
  localparam int unsigned EW  = $clog2(NE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NE-1:0]     evt_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NH-1:0]     host_irq_o
);
  logic          wr, gen_en, set_stb, clr_stb;
  logic [NH-1:0] host_en;
  logic [NE-1:0] pol, typ, en, pend;
  logic [31:0]   cmap [CMR];
  logic [31:0]   hmap [HMR];
  logic [EW-1:0] idx;
  logic [NC-1:0] ch_any;
  logic [EW-1:0] ch_evt [NC];
  logic [31:0]   pridx [NH];

  assign wr = bus_req_i & bus_we_i;

  evt_irq_regs #(.NE(NE), .NC(NC), .NH(NH)) i_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .gen_en_o(gen_en), .host_en_o(host_en), .pol_o(pol), .typ_o(typ), .en_o(en),
    .cmap_o(cmap), .hmap_o(hmap), .set_o(set_stb), .clr_o(clr_stb), .idx_o(idx)
  );

  evt_irq_status #(.NE(NE)) i_status (
    .clk_i, .rst_ni, .evt_i, .pol_i(pol), .typ_i(typ),
    .set_i(set_stb), .clr_i(clr_stb), .idx_i(idx), .pend_o(pend)
  );

  evt_irq_chsel #(.NE(NE), .NC(NC)) i_chsel (
    .req_i(pend & en), .cmap_i(cmap), .any_o(ch_any), .evt_o(ch_evt)
  );

  for (genvar h = 0; h < NH; h++) begin : g_host
    evt_irq_hostsel #(.NC(NC), .EW(EW), .HID(h)) i_hostsel (
      .any_i(ch_any), .evt_i(ch_evt), .hmap_i(hmap), .gen_en_i(gen_en),
      .host_en_i(host_en[h]), .pridx_o(pridx[h]), .irq_o(host_irq_o[h])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADR_CTRL) bus_rdata_o = 32'(gen_en);
    if (bus_addr_i == ADR_HEN)  bus_rdata_o = 32'(host_en);
    for (int k = 0; k < NW; k++) begin
      if (bus_addr_i == ADDR_W'(ADR_PEND + 4 * k)) bus_rdata_o = pend[32*k +: 32];
      if (bus_addr_i == ADDR_W'(ADR_EN + 4 * k))   bus_rdata_o = en[32*k +: 32];
      if (bus_addr_i == ADDR_W'(ADR_POL + 4 * k))  bus_rdata_o = pol[32*k +: 32];
      if (bus_addr_i == ADDR_W'(ADR_TYPE + 4 * k)) bus_rdata_o = typ[32*k +: 32];
    end
    for (int k = 0; k < CMR; k++)
      if (bus_addr_i == ADDR_W'(ADR_CMAP + 4 * k)) bus_rdata_o = cmap[k];
    for (int k = 0; k < HMR; k++)
      if (bus_addr_i == ADDR_W'(ADR_HMAP + 4 * k)) bus_rdata_o = hmap[k];
    for (int h = 0; h < NH; h++)
      if (bus_addr_i == ADDR_W'(ADR_PRIDX + 4 * h)) bus_rdata_o = pridx[h];
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned NE = NUM_EVT,
  parameter int unsigned NH = NUM_HOST,
  localparam int unsigned EW = $clog2(NE)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [NH-1:0]     host_irq_o,
  input logic [NE-1:0]     pend_i,
  input logic [NE-1:0]     en_i,
  input logic              gen_en_i,
  input logic [NH-1:0]     host_en_i
);
  logic wr, ok, idx_port;
  assign wr = bus_req_i && bus_we_i;
  assign ok = bus_wdata_i < 32'(NE);
  assign idx_port = bus_addr_i == ADR_SET || bus_addr_i == ADR_CLR ||
                    bus_addr_i == ADR_ENSET || bus_addr_i == ADR_ENCLR;

  assert_set_marks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && ok && bus_addr_i == ADR_SET) |=> pend_i[$past(bus_wdata_i[EW-1:0])]);

  assert_enable_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && ok && bus_addr_i == ADR_ENSET) |=> en_i[$past(bus_wdata_i[EW-1:0])]);

  assert_enable_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && ok && bus_addr_i == ADR_ENCLR) |=> !en_i[$past(bus_wdata_i[EW-1:0])]);

  assert_range_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !ok && idx_port) |=> $stable(en_i));

  assert_global_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|host_irq_o) |-> gen_en_i);

  assert_host_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_irq_o & ~host_en_i) == '0);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NE(NE), .NH(NH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .host_irq_o(host_irq_o),
  .pend_i(pend), .en_i(en), .gen_en_i(gen_en), .host_en_i(host_en)
);

// File: tb/test_evt_irq_ctrl.sv
`timescale 1ns/1ps
module test_evt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  localparam logic [31:0] NONE = 32'h8000_0000;

  always #2 clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .host_irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    addr = a;
    #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 pend lo", 12'h020, 0);
    rd_chk("R1 pend hi", 12'h024, 0);
    rd_chk("R1 pridx0", 12'h200, NONE);
    rd_chk("R1 pridx9", 12'h224, NONE);
    rd_chk("R1 pol lo", 12'h030, 32'hFFFF_FFFF);
    rd_chk("R1 cmap0", 12'h100, 0);
    chk("R1 host_irq", 32'(irq), 0);
  endtask

  task automatic t_set_clear();
    wr(12'h000, 1);
    wr(12'h014, 32'h3FF);
    wr(12'h00C, 5);
    wr(12'h004, 5);
    rd_chk("R2 pend after set", 12'h020, 32'h20);
    rd_chk("R11 enable readback R4", 12'h028, 32'h20);
    rd_chk("R9 pridx0 single", 12'h200, 5);
    chk("R10 host0 asserted", 32'(irq), 32'h001);
    wr(12'h008, 5);
    rd_chk("R3 pend after clear", 12'h020, 0);
    rd_chk("R9 pridx0 empty", 12'h200, NONE);
    chk("R10 host idle", 32'(irq), 0);
  endtask

  task automatic t_mask();
    wr(12'h004, 5);
    wr(12'h010, 5);
    rd_chk("R4 pend kept when masked", 12'h020, 32'h20);
    rd_chk("R4 enable cleared", 12'h028, 0);
    rd_chk("R4 masked not reported", 12'h200, NONE);
    wr(12'h00C, 5);
    rd_chk("R4 unmask reports", 12'h200, 5);
    wr(12'h008, 5);
  endtask

  task automatic t_range();
    wr(12'h004, 64);
    rd_chk("R5 set 64 lo", 12'h020, 0);
    rd_chk("R5 set 64 hi", 12'h024, 0);
    wr(12'h010, 69);
    rd_chk("R5 enclr 69 ignored", 12'h028, 32'h20);
    wr(12'h004, 32'h105);
    rd_chk("R5 set 0x105 ignored", 12'h020, 0);
  endtask

  task automatic t_type();
    wr(12'h00C, 40);
    @(negedge clk); evt[40] = 1'b1;
    @(negedge clk);
    rd_chk("R7 pulse edge latched", 12'h024, 32'h100);
    rd_chk("R9 pridx0 event 40", 12'h200, 40);
    wr(12'h008, 40);
    rd_chk("R7 pulse clear while held", 12'h024, 0);
    wr(12'h03C, 32'h100);
    rd_chk("R11 type readback", 12'h03C, 32'h100);
    @(negedge clk);
    rd_chk("R7 level sets while active", 12'h024, 32'h100);
    wr(12'h008, 40);
    rd_chk("R7 level survives clear", 12'h024, 32'h100);
    @(negedge clk); evt[40] = 1'b0;
    wr(12'h008, 40);
    rd_chk("R7 level clears when idle", 12'h024, 0);
    wr(12'h03C, 0);
  endtask

  task automatic t_polarity();
    wr(12'h030, 32'hFFFF_FFF7);
    rd_chk("R6 pol readback", 12'h030, 32'hFFFF_FFF7);
    @(negedge clk);
    rd_chk("R6 active low low input", 12'h020, 32'h8);
    evt[3] = 1'b1;
    wr(12'h008, 3);
    rd_chk("R6 high input inactive", 12'h020, 0);
    @(negedge clk); evt[3] = 1'b0;
    @(negedge clk);
    rd_chk("R6 falling edge detected", 12'h020, 32'h8);
    wr(12'h008, 3);
    wr(12'h030, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk("R6 restored no pend", 12'h020, 0);
  endtask

  task automatic t_priority();
    wr(12'h00C, 7);
    wr(12'h00C, 4);
    wr(12'h004, 7);
    wr(12'h004, 4);
    rd_chk("R9 lower event in channel", 12'h200, 4);
    wr(12'h008, 4);
    rd_chk("R9 next event", 12'h200, 7);
    wr(12'h104, 32'h0200_0000);
    rd_chk("R11 cmap readback", 12'h104, 32'h0200_0000);
    wr(12'h00C, 10);
    wr(12'h004, 10);
    rd_chk("R9 ch0 beats ch2", 12'h200, 10);
    wr(12'h108, 32'h0001_0000);
    rd_chk("R9 ch1 beats ch2 despite number", 12'h200, 10);
    wr(12'h180, 32'h0003_0000);
    rd_chk("R8 host0 keeps ch1", 12'h200, 10);
    rd_chk("R8 host3 gets ch2", 12'h20C, 7);
    chk("R10 hosts 0 and 3", 32'(irq), 32'h009);
    wr(12'h108, 32'h000C_0000);
    rd_chk("R8 channel 12 unrouted", 12'h200, NONE);
    chk("R8 only host3", 32'(irq), 32'h008);
  endtask

  task automatic t_gating();
    wr(12'h014, 32'h3F7);
    chk("R10 host enable gates", 32'(irq), 0);
    rd_chk("R10 index unaffected", 12'h20C, 7);
    wr(12'h014, 32'h3FF);
    chk("R10 host enable restored", 32'(irq), 32'h008);
    wr(12'h000, 0);
    chk("R10 global gate", 32'(irq), 0);
    wr(12'h000, 1);
    wr(12'h008, 7);
    wr(12'h008, 10);
    wr(12'h104, 0);
    wr(12'h108, 0);
    wr(12'h180, 0);
    chk("R10 all idle", 32'(irq), 0);
  endtask

  task automatic t_collision();
    wr(12'h00C, 20);
    @(negedge clk);
    evt[20] = 1'b1;
    req = 1'b1; we = 1'b1; addr = 12'h008; wdata = 20;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd_chk("R3 edge wins over clear", 12'h020, 32'h0010_0000);
    wr(12'h008, 20);
    rd_chk("R3 later clear empties", 12'h020, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_mask();
    t_range();
    t_type();
    t_polarity();
    t_priority();
    t_gating();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule